// File: doc/BRIEF.md
# I2C SCL Period Generator

This block derives the serial clock for an I2C master from a fast peripheral clock. A packed clock-control word carries a prescaler selector in its low bits and a period selector above it. The prescaler turns the peripheral clock into a one-cycle internal tick. A phase counter, advanced by that tick, draws a free-running SCL waveform whose period is a fixed base of 20 ticks, plus 8 ticks per period step, plus a small compensation count that absorbs the bus rise and fall times.

When the bit engine raises `enable`, SDA is expected to fall at once for the start condition. The generator keeps SCL high for a programmable setup gap and only then opens the first low phase. During every period it pulses `launch_stb` in the middle of the low phase, where the engine changes SDA. It pulses `sample_stb` in the middle of the high phase, where the engine reads SDA. A `hold` input from the engine's stretching logic freezes the counter while SCL is low. Dropping `enable` returns SCL high on the next clock.

Top module: `scl_divgen`

## Requirements
- R1: After reset, `scl_out` is 1, and `first_gap`, `launch_stb` and `sample_stb` are 0.
- R2: The prescaler selector C is `clk_ctrl[PRESC_W-1:0]`. `tick` is high for one cycle in every C+1 peripheral clock cycles, and it stays high on every cycle when C is 0.
- R3: The period selector S is `clk_ctrl[CTRL_W-1:PRESC_W]`, a 6-bit value from 0 to 63. With P = 20 + 8·S + `rf_comp` ticks, every SCL low phase lasts L = ceil(P/2) ticks, which is L·(C+1) clock cycles.
- R4: Every SCL high phase inside a run lasts P − L ticks.
- R5: After `enable` rises, `first_gap` is high and SCL stays high for `first_setup` + 2 ticks (a setting of 15 gives 17 ticks). The first SCL low phase begins directly after that gap.
- R6: `launch_stb` pulses exactly once per low phase, for one cycle, on the tick that closes low-phase tick number floor(L/2), counting from 0.
- R7: `sample_stb` pulses exactly once per high phase, for one cycle, on the tick that closes high-phase tick number floor((P−L)/2). It never coincides with `launch_stb`.
- R8: While `hold` is 1 and SCL is in its low phase, the counter does not advance, SCL stays low and no `launch_stb` appears. After release, the rest of the low phase runs normally.
- R9: With `enable` at 0, `scl_out` is 1 from the next clock on. The gap and both strobes stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request from the bit engine |
| hold | input | 1 | Freezes the low phase (clock stretching) |
| clk_ctrl | input | CTRL_W | Period selector above prescaler selector |
| rf_comp | input | COMP_W | Rise/fall compensation ticks |
| first_setup | input | SETUP_W | Setup gap setting for the first bit |
| tick | output | 1 | Internal clock enable |
| scl_out | output | 1 | SCL waveform (registered) |
| first_gap | output | 1 | High during the first-bit setup gap |
| launch_stb | output | 1 | Mid-low strobe for driving data |
| sample_stb | output | 1 | Mid-high strobe for sampling data |

## Verification
The setup gap is measured in ticks that are seen while `first_gap` is high, and it must end on the same edge at which SCL falls. Phase lengths are counted in clock cycles, from the first cycle after an SCL edge to the next edge. The prescaler counter restarts on the tick that opens the run, so the bench expects each strobe exactly C cycles after its (k·(C+1))-th phase cycle. `enable` and `hold` are driven on falling edges, so a change takes effect at the next rising edge. The bench then reads the registered SCL one half-cycle later, and all sampling happens on falling edges to keep that timing.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int CYC_W      = 16;
  localparam int BASE_TICKS = 20;
  localparam int STEP_SHIFT = 3;

  typedef logic [CYC_W-1:0] cyc_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} seq_e;

  function automatic cyc_t period_of(input cyc_t step, input cyc_t comp);
    return cyc_t'(BASE_TICKS) + (step << STEP_SHIFT) + comp;
  endfunction

  function automatic cyc_t low_of(input cyc_t period);
    return (period + cyc_t'(1)) >> 1;
  endfunction

  function automatic cyc_t high_of(input cyc_t period);
    return period - low_of(period);
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRESC_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] div_sel,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick = (cnt_q >= div_sel);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0 && $stable(div_sel)) |=> !tick);
  p_tick_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == '0) |-> tick);
endmodule

// File: rtl/scl_start_seq.sv
module scl_start_seq
  import scl_div_pkg::*;
#(
  parameter int SETUP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               enable,
  input  logic [SETUP_W-1:0] setup_val,
  output seq_e               state,
  output logic               enter_run
);
  localparam int DW = SETUP_W + 1;

  seq_e          state_q;
  logic [DW-1:0] dcnt_q;
  logic [DW-1:0] gap_last;

  assign gap_last  = DW'(setup_val) + DW'(1);
  assign enter_run = (state_q == ST_SETUP) && enable && tick && (dcnt_q == gap_last);
  assign state     = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
    end else if (!enable) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (tick) begin
          state_q <= ST_SETUP;
          dcnt_q  <= '0;
        end
        ST_SETUP: if (tick) begin
          if (dcnt_q == gap_last) state_q <= ST_RUN;
          else                    dcnt_q  <= dcnt_q + 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  p_gap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP) |-> (dcnt_q <= gap_last));
  p_gap_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && enable && tick) |=> (state_q == ST_SETUP && dcnt_q == '0));
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
  import scl_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic run,
  input  logic enter_run,
  input  logic hold,
  input  cyc_t period,
  input  cyc_t low_len,
  input  cyc_t high_len,
  output logic scl_out,
  output logic launch_stb,
  output logic sample_stb
);
  cyc_t pos_q, pos_nx, launch_pos, sample_pos;
  logic scl_q, frozen, adv;

  assign frozen     = hold && (pos_q < low_len);
  assign adv        = run && enable && tick && !frozen;
  assign pos_nx     = (pos_q >= period - cyc_t'(1)) ? '0 : pos_q + cyc_t'(1);
  assign launch_pos = low_len >> 1;
  assign sample_pos = low_len + (high_len >> 1);
  assign launch_stb = adv && (pos_q == launch_pos);
  assign sample_stb = adv && (pos_q == sample_pos);
  assign scl_out    = scl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      scl_q <= 1'b1;
    end else if (!enable || (!run && !enter_run)) begin
      pos_q <= '0;
      scl_q <= 1'b1;
    end else if (enter_run) begin
      pos_q <= '0;
      scl_q <= 1'b0;
    end else if (adv) begin
      pos_q <= pos_nx;
      scl_q <= (pos_nx >= low_len);
    end
  end

  p_launch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb |-> !scl_out);
  p_sample_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> scl_out);
  p_fall_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $fell(scl_out)) |-> (pos_q == '0));
  p_rise_at_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run && $rose(scl_out)) |-> (pos_q == low_len));
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && enable && hold && pos_q < low_len) |=> ($stable(pos_q) && !scl_out));
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> scl_out);
endmodule

// File: rtl/scl_divgen.sv
module scl_divgen
  import scl_div_pkg::*;
#(
  parameter int PRESC_W = 3,
  parameter int STEP_W  = 6,
  parameter int COMP_W  = 4,
  parameter int SETUP_W = 4,
  localparam int CTRL_W = STEP_W + PRESC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               hold,
  input  logic [CTRL_W-1:0]  clk_ctrl,
  input  logic [COMP_W-1:0]  rf_comp,
  input  logic [SETUP_W-1:0] first_setup,
  output logic               tick,
  output logic               scl_out,
  output logic               first_gap,
  output logic               launch_stb,
  output logic               sample_stb
);
  logic [PRESC_W-1:0] div_sel;
  logic [STEP_W-1:0]  step_sel;
  cyc_t               period, low_len, high_len;
  seq_e               state;
  logic               enter_run, run;

  assign div_sel   = clk_ctrl[PRESC_W-1:0];
  assign step_sel  = clk_ctrl[CTRL_W-1:PRESC_W];
  assign period    = period_of(cyc_t'(step_sel), cyc_t'(rf_comp));
  assign low_len   = low_of(period);
  assign high_len  = high_of(period);
  assign run       = (state == ST_RUN);
  assign first_gap = (state == ST_SETUP);

  scl_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .tick(tick)
  );

  scl_start_seq #(.SETUP_W(SETUP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable),
    .setup_val(first_setup), .state(state), .enter_run(enter_run)
  );

  scl_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .run(run),
    .enter_run(enter_run), .hold(hold), .period(period), .low_len(low_len),
    .high_len(high_len), .scl_out(scl_out), .launch_stb(launch_stb),
    .sample_stb(sample_stb)
  );

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch_stb && sample_stb));
  p_gap_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    first_gap |-> scl_out);
endmodule

// File: tb/scl_divgen_test.sv
module scl_divgen_test;
  localparam int PRESC_W = 3;
  localparam int STEP_W  = 6;
  localparam int CTRL_W  = STEP_W + PRESC_W;

  logic clk = 1'b0;
  logic rst_n, enable, hold;
  logic [CTRL_W-1:0] clk_ctrl;
  logic [3:0] rf_comp, first_setup;
  logic tick, scl_out, first_gap, launch_stb, sample_stb;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  scl_divgen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold(hold),
    .clk_ctrl(clk_ctrl), .rf_comp(rf_comp), .first_setup(first_setup),
    .tick(tick), .scl_out(scl_out), .first_gap(first_gap),
    .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup_cfg(input int c, input int s, input int r, input int d);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    clk_ctrl    = CTRL_W'((s << PRESC_W) | c);
    rf_comp     = 4'(r);
    first_setup = 4'(d);
    @(negedge clk);
  endtask

  task automatic run_cfg(input int c, input int s, input int r, input int d);
    int p, l, h, cnt, off, nl, ns;
    p = 20 + 8 * s + r;
    l = (p + 1) / 2;
    h = p - l;
    setup_cfg(c, s, r, d);
    // R2: spacing between ticks
    while (!tick) @(negedge clk);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!tick);
    chk(cnt == c + 1, "R2 tick spacing", cnt, c + 1);
    // R5: setup gap in ticks
    enable = 1'b1;
    cnt = 0;
    @(negedge clk);
    while (scl_out) begin
      if (first_gap && tick) cnt++;
      @(negedge clk);
    end
    chk(cnt == d + 2, "R5 setup gap ticks", cnt, d + 2);
    chk(first_gap == 1'b0, "R5 gap closed at fall", int'(first_gap), 0);
    // R3 / R6: low phase
    cnt = 0; off = -1; nl = 0; ns = 0;
    while (!scl_out) begin
      if (launch_stb) begin nl++; off = cnt; end
      if (sample_stb) ns++;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == l * (c + 1), "R3 low cycles", cnt, l * (c + 1));
    chk(nl == 1 && ns == 0, "R6 one launch in low", nl * 10 + ns, 10);
    chk(off == (l / 2) * (c + 1) + c, "R6 launch offset", off, (l / 2) * (c + 1) + c);
    // R4 / R7: high phase
    cnt = 0; off = -1; nl = 0; ns = 0;
    while (scl_out) begin
      if (sample_stb) begin ns++; off = cnt; end
      if (launch_stb) nl++;
      cnt++;
      @(negedge clk);
    end
    chk(cnt == h * (c + 1), "R4 high cycles", cnt, h * (c + 1));
    chk(ns == 1 && nl == 0, "R7 one sample in high", ns * 10 + nl, 10);
    chk(off == (h / 2) * (c + 1) + c, "R7 sample offset", off, (h / 2) * (c + 1) + c);
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cl[4];
    int sl[4];
    int cnt, nl, c, l;
    cl = '{0, 1, 3, 7};
    sl = '{0, 1, 22, 63};
    rst_n = 1'b0; enable = 1'b0; hold = 1'b0;
    clk_ctrl = '0; rf_comp = '0; first_setup = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(scl_out == 1'b1, "R1 scl after reset", int'(scl_out), 1);
    chk(!first_gap && !launch_stb && !sample_stb, "R1 strobes after reset",
        int'({first_gap, launch_stb, sample_stb}), 0);

    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        int r, d;
        r = (i * 7 + j * 5) % 16;
        d = (i * 4 + j) % 16;
        if (i == 3 && j == 3) r = 15;
        run_cfg(cl[i], sl[j], r, d);
      end
    end

    // R9: enable drop mid-low returns SCL high
    run_cfg(1, 0, 0, 0);
    while (scl_out) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_out == 1'b1, "R9 scl high after disable", int'(scl_out), 1);
    cnt = 0;
    repeat (60) begin
      if (!scl_out || first_gap || launch_stb || sample_stb) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R9 quiet while disabled", cnt, 0);

    // R8: hold freezes the low phase
    c = 1;
    l = 10;
    setup_cfg(c, 0, 0, 0);
    hold = 1'b1;
    enable = 1'b1;
    while (scl_out) @(negedge clk);
    nl = 0;
    repeat (200) begin
      if (launch_stb) nl++;
      @(negedge clk);
    end
    chk(scl_out == 1'b0, "R8 scl held low", int'(scl_out), 0);
    chk(nl == 0, "R8 no launch during hold", nl, 0);
    hold = 1'b0;
    cnt = 0; nl = 0;
    while (!scl_out) begin
      if (launch_stb) nl++;
      cnt++;
      @(negedge clk);
    end
    chk(cnt >= (l - 1) * (c + 1) + 1 && cnt <= l * (c + 1), "R8 low remainder", cnt, l * (c + 1));
    chk(nl == 1, "R8 launch after release", nl, 1);
    enable = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule